// File: doc/BRIEF.md
# Wide Free-Running Counter with Snapshot Readout

This block keeps a wide up-counter that advances by one on every clock in which the count-enable tick is high. Typically the tick is a strobe derived from the system's reference oscillator. The counter cannot be stopped, loaded or cleared except by reset. It passes from all-ones to zero without any flag.

Software cannot read a wide value in one access over a 32-bit register port. To read the count, it sets a request bit in the control register. The block then copies the whole count into a holding register in one step and clears the request bit. Software polls the bit until it reads zero. It then reads the two data words in either order. Both words always come from the same captured value, and the live count never reaches the read port directly.

Top module: `snapcnt_top`

## Requirements
- R1: After reset, the counter, the snapshot and the control register are all zero, so offsets 0xA0, 0xA4 and 0xA8 all read 0.
- R2: The counter rises by exactly one at each clock edge where `tick_i` is 1, and holds its value at each edge where `tick_i` is 0.
- R3: A write to offset 0xA0 with data bit 1 set starts a capture. From the next cycle, offset 0xA0 reads with bit 1 equal to 1.
- R4: Bit 1 of offset 0xA0 stays 1 for exactly two cycles and returns to 0 on the second clock edge after the write edge. On that same edge the snapshot takes the count value held just before it.
- R5: Offset 0xA4 returns snapshot bits 31..0 and offset 0xA8 returns bits 63..32. Bits above `CNT_W` read as 0. Both words come from the same captured value, whatever the read order.
- R6: The snapshot does not change between captures while the live counter keeps running.
- R7: The counter wraps from all-ones to zero and keeps counting.
- R8: A capture request written while a capture is pending is ignored. The pending capture completes at its original time with its original value.
- R9: Writes to 0xA0 with bit 1 clear have no effect, and neither do writes to 0xA4 or 0xA8. Control bits other than bit 1 always read 0.
- R10: Reads of any offset other than 0xA0, 0xA4 and 0xA8 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Count enable; one increment per clock it is high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset for reads and writes |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |

## Verification
The design has two internal states that can go wrong: the capture sequencer and the counter. A capture sequencer that holds a stale or over-long state shows at offset 0xA0 within three cycles of a request: the ready bit clears early, clears late, or never clears. A counter or snapshot that goes wrong shows up on the first readout after the capture completes. The bench compares that readout against a count of the ticks it drove. A narrow instance built with an 8-bit counter makes the wrap observable within a few hundred ticks. On a wrong wrap, the low word goes back to zero on the wrong tick.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned WIDE_W    = 64;
  localparam int unsigned REQ_BIT   = 1;
  localparam logic [7:0]  OFS_CTRL  = 8'hA0;
  localparam logic [7:0]  OFS_LOW   = 8'hA4;
  localparam logic [7:0]  OFS_HIGH  = 8'hA8;

  typedef enum logic [1:0] {
    SNAP_IDLE  = 2'd0,
    SNAP_ARMED = 2'd1,
    SNAP_TAKE  = 2'd2
  } snap_state_e;
endpackage

// File: rtl/snapcnt_rst_sync.sv
module snapcnt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/snapcnt_counter.sv
module snapcnt_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned LO_W = (CNT_W > 32) ? 32 : CNT_W;
  localparam int unsigned HI_W = (CNT_W > 32) ? (CNT_W - 32) : 1;

  logic [LO_W-1:0] lo_q, lo_d;

  // Low segment: next state
  always_comb begin
    lo_d = lo_q;
    if (tick_i) lo_d = lo_q + LO_W'(1);
  end

  // Low segment: register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else        lo_q <= lo_d;
  end

  generate
    if (CNT_W > 32) begin : g_split
      // Upper segment advances only when the low segment rolls over,
      // keeping the carry chain of each adder at most 32 bits.
      logic [HI_W-1:0] hi_q, hi_d;
      logic            carry;

      assign carry = tick_i & (&lo_q);

      always_comb begin
        hi_d = hi_q;
        if (carry) hi_d = hi_q + HI_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= '0;
        else        hi_q <= hi_d;
      end

      assign cnt_o = {hi_q, lo_q};
    end else begin : g_flat
      assign cnt_o = lo_q;
    end
  endgenerate
endmodule

// File: rtl/snapcnt_latch.sv
module snapcnt_latch
  import snapcnt_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] snap_o
);
  snap_state_e      state_q, state_d;
  logic             cap_en;
  logic [CNT_W-1:0] snap_q, snap_d;

  // Sequencer next state: request -> armed -> take (capture) -> idle
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    case (state_q)
      SNAP_IDLE:  if (req_i) state_d = SNAP_ARMED;
      SNAP_ARMED: state_d = SNAP_TAKE;
      SNAP_TAKE: begin
        state_d = SNAP_IDLE;
        cap_en  = 1'b1;
      end
      default:    state_d = SNAP_IDLE;
    endcase
  end

  always_comb begin
    snap_d = snap_q;
    if (cap_en) snap_d = cnt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SNAP_IDLE;
      snap_q  <= '0;
    end else begin
      state_q <= state_d;
      snap_q  <= snap_d;
    end
  end

  assign busy_o = (state_q != SNAP_IDLE);
  assign snap_o = snap_q;
endmodule

// File: rtl/snapcnt_regs.sv
module snapcnt_regs
  import snapcnt_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  snap_i,
  output logic              req_o,
  output logic [REG_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(OFS_LOW);
  localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(OFS_HIGH);

  logic [WIDE_W-1:0] snap_wide;
  logic              hit_ctrl;
  logic              wdata_unused;

  always_comb begin
    snap_wide            = '0;
    snap_wide[CNT_W-1:0] = snap_i;
  end

  assign hit_ctrl     = (addr_i == A_CTRL);
  assign req_o        = wr_en_i & hit_ctrl & wdata_i[REQ_BIT];
  assign wdata_unused = ^{wdata_i[REG_W-1:REQ_BIT+1], wdata_i[REQ_BIT-1:0]};

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl)              rdata_o[REQ_BIT] = busy_i;
    else if (addr_i == A_LOW)  rdata_o = snap_wide[REG_W-1:0];
    else if (addr_i == A_HIGH) rdata_o = snap_wide[WIDE_W-1:REG_W];
  end
endmodule

// File: rtl/snapcnt_top.sv
module snapcnt_top
  import snapcnt_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  logic             rst_n;
  logic             req;
  logic             busy;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] snap_q;

  snapcnt_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n)
  );

  snapcnt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .cnt_o  (cnt_q)
  );

  snapcnt_latch #(.CNT_W(CNT_W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req),
    .cnt_i  (cnt_q),
    .busy_o (busy),
    .snap_o (snap_q)
  );

  snapcnt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .busy_i  (busy),
    .snap_i  (snap_q),
    .req_o   (req),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/snapcnt_chk.sv
module snapcnt_chk
  import snapcnt_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  snap,
  input logic              busy
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(OFS_LOW);
  localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(OFS_HIGH);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> cnt == $past(cnt) + CNT_W'(1));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt));

  a_r4_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);

  a_r5_coherent: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> snap == $past(cnt));

  a_r6_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap) |-> $fell(busy));

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && (&cnt)) |=> cnt == '0);

  a_r9_ctrl_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == A_CTRL) |-> (rdata_o & ~(32'd1 << REQ_BIT)) == 32'd0);

  a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i != A_CTRL && addr_i != A_LOW && addr_i != A_HIGH) |-> rdata_o == 32'd0);
endmodule

bind snapcnt_top snapcnt_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick_i  (tick_i),
  .addr_i  (addr_i),
  .rdata_o (rdata_o),
  .cnt     (cnt_q),
  .snap    (snap_q),
  .busy    (busy)
);

// File: tb/test_snapcnt_top.sv
`timescale 1ns/1ps
module test_snapcnt_top;
  localparam logic [7:0] A_CTRL = 8'hA0;
  localparam logic [7:0] A_LOW  = 8'hA4;
  localparam logic [7:0] A_HIGH = 8'hA8;

  typedef struct packed {
    logic [15:0] cyc;   // cycles to run before the capture
    logic [1:0]  mode;  // 0 idle, 1 every cycle, 2 every other cycle
    logic        dbl;   // repeat the request while pending
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{16'd12,  2'd1, 1'b0},
    '{16'd40,  2'd2, 1'b0},
    '{16'd9,   2'd0, 1'b1},
    '{16'd0,   2'd1, 1'b0},
    '{16'd33,  2'd1, 1'b1},
    '{16'd100, 2'd2, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n_i = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata_big, rdata_nar;
  logic [63:0] ref_cnt;
  logic [63:0] last_snap;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  snapcnt_top i_snapcnt_top (
    .clk(clk), .rst_n_i(rst_n_i), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_big));

  snapcnt_top #(.CNT_W(8)) i_snapcnt_top_narrow (
    .clk(clk), .rst_n_i(rst_n_i), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata_nar));

  // Tick count seen by the bench: the value the counter must hold.
  always @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)  ref_cnt <= '0;
    else if (tick) ref_cnt <= ref_cnt + 64'd1;
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] db, output logic [31:0] dn);
    addr = a;
    #1;
    db = rdata_big;
    dn = rdata_nar;
  endtask

  task automatic do_reset();
    rst_n_i = 1'b0;
    tick = 1'b0;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n_i = 1'b1;
    repeat (3) @(negedge clk);
    last_snap = '0;
  endtask

  task automatic run(input int cyc, input logic [1:0] mode);
    for (int i = 0; i < cyc; i++) begin
      tick = (mode == 2'd1) || (mode == 2'd2 && i[0]);
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic check_snap(input string rq, input logic [63:0] exp, input bit hi_first);
    logic [31:0] b, n, b2, n2;
    if (hi_first) begin
      rd(A_HIGH, b, n);  rd(A_LOW, b2, n2);
      check(rq, b, exp[63:32]); check(rq, n, 32'h0);
      check(rq, b2, exp[31:0]); check(rq, n2, {24'h0, exp[7:0]});
    end else begin
      rd(A_LOW, b, n);   rd(A_HIGH, b2, n2);
      check(rq, b, exp[31:0]);  check(rq, n, {24'h0, exp[7:0]});
      check(rq, b2, exp[63:32]); check(rq, n2, 32'h0);
    end
  endtask

  // Called at a negedge; leaves at a negedge with the capture complete.
  task automatic capture(input bit dbl, input bit hi_first);
    logic [31:0] b, n;
    logic [63:0] exp;
    wr_en = 1'b1; addr = A_CTRL; wdata = 32'h0000_0002;
    @(negedge clk);                       // write edge E0 passed
    wr_en = dbl;                          // R8: second request sampled at E1
    rd(A_CTRL, b, n);
    check("R3 request bit set", b, 32'h2);
    check("R3 request bit set narrow", n, 32'h2);
    @(negedge clk);                       // E1 passed
    wr_en = 1'b0;
    exp = ref_cnt;                        // count held just before E2
    rd(A_CTRL, b, n);
    check(dbl ? "R8 pending unchanged" : "R4 still pending", b, 32'h2);
    @(negedge clk);                       // E2 passed: capture done
    rd(A_CTRL, b, n);
    check(dbl ? "R8 clears on original time" : "R4 clears after two cycles", b, 32'h0);
    check("R4 narrow clears", n, 32'h0);
    check_snap(dbl ? "R8 original value" : "R5 coherent snapshot", exp, hi_first);
    last_snap = exp;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] b, n;
    do_reset();

    // R1: reset state
    rd(A_CTRL, b, n); check("R1 ctrl reset", b, 32'h0); check("R1 ctrl reset narrow", n, 32'h0);
    check_snap("R1 snapshot reset", 64'h0, 1'b0);

    // R10: unmapped offsets
    rd(8'h00, b, n); check("R10 offset 00", b, 32'h0);
    rd(8'hAC, b, n); check("R10 offset AC", b, 32'h0);
    rd(8'hA1, b, n); check("R10 offset A1", b, 32'h0);

    // Vector walk: R2 counting patterns, R3/R4/R5 capture, R8 repeats, R6 hold
    for (int v = 0; v < NVEC; v++) begin
      run(int'(VEC[v].cyc), VEC[v].mode);
      capture(VEC[v].dbl, v[0]);
      run(7, 2'd1);
      check_snap("R6 snapshot held while counting", last_snap, ~v[0]);
    end

    // R2 idle: no ticks, count unchanged
    capture(1'b0, 1'b0);
    b = last_snap[31:0];
    run(10, 2'd0);
    capture(1'b0, 1'b1);
    check("R2 hold without tick", last_snap[31:0], b);

    // R9: writes without effect
    wr_en = 1'b1; addr = A_CTRL; wdata = 32'hFFFF_FFFD;
    @(negedge clk);
    wr_en = 1'b0;
    rd(A_CTRL, b, n); check("R9 ctrl write w/o bit1", b, 32'h0);
    run(3, 2'd1);
    rd(A_CTRL, b, n); check("R9 ctrl still idle", b, 32'h0);
    wr_en = 1'b1; addr = A_LOW; wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    addr = A_HIGH; wdata = 32'hCAFE_F00D;
    @(negedge clk);
    wr_en = 1'b0;
    check_snap("R9 data words ignore writes", last_snap, 1'b0);

    // R7: wrap of the 8-bit instance
    do_reset();
    check_snap("R1 snapshot after second reset", 64'h0, 1'b1);
    run(255, 2'd1);
    capture(1'b0, 1'b0);
    check("R7 at all-ones", last_snap[31:0], 32'h0000_00FF);
    run(1, 2'd1);
    capture(1'b0, 1'b1);
    check("R7 wide count past 255", last_snap[31:0], 32'h0000_0100);
    run(3, 2'd1);
    capture(1'b0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule